// File: doc/BRIEF.md
# Typed Peripheral Register Bank

This block is a small register file for a peripheral on an 8-bit data, 16-bit address bus with active-low read, write and request strobes. A build-time parameter picks the request strobe it listens to: the I/O request or the memory request. The bank claims one aligned window of addresses. Within that window it holds a fixed, ordered list of typed registers. Each type has its own side effects: a plain status input, a config value, a set-by-write/clear-by-hardware value, a value that pulses a strobe when written, a status input that pulses a strobe when read, and two sticky interrupt registers, each followed by its mask.

Reads are combinational from the strobes, so the CPU sees data in the same bus cycle. The bank drives a data-output-enable whenever one of its registers is read. If no register is selected, the read data falls back to the interrupt vector. The vector belongs to the lowest-numbered interrupt register whose unmasked flag is up, and the active-low interrupt line is low while any such flag is up.

Top module: `periph_regbank`

## Requirements
- R1: The window size is 2^OFF_W with OFF_W = ceil(log2(9)) = 4. The bank is selected only when addr[15:4] equals BASE_ADDR[15:4] (default 0x004) and the chosen request strobe is low. An access outside the window changes no register and raises no strobe or output enable.
- R2: With MEM_MAPPED = 0 only io_req_n qualifies an access, and mem_req_n has no effect. With MEM_MAPPED = 1 the roles swap.
- R3: Register offsets are fixed: 0 status, 1 config, 2 soft-set, 3 write-strobe, 4 read-strobe, 5 interrupt A, 6 mask A, 7 interrupt B, 8 mask B. During a read (rd_n low) of offsets 0..8, doe is 1 and rd_data shows that register in the same cycle. Offsets 9..15 give doe = 0.
- R4: The config register loads wr_data on the clock edge of a write. Its reset value is 0xA5.
- R5: A write ORs wr_data into the soft-set register. Each soft_clr bit clears its bit at the edge, and the clear wins over a write in the same cycle. Its reset value is 0x0F.
- R6: A write loads the write-strobe register (reset 0x00). wstb_pulse is 1 for exactly the one cycle that follows the write edge.
- R7: A read at offset 4 returns rstb_in. rstb_pulse is 1 for the one cycle that follows the read edge.
- R8: An interrupt register keeps its bits: at each edge it takes (irq_set | value), with the bits written as 1 cleared. A clear wins over a set in the same cycle. Its reset value is 0.
- R9: A mask register (reset 0xFF) blocks its interrupt bit where the mask bit is 1. One edge after (status AND NOT mask) becomes nonzero, int_n goes low. One edge after it returns to zero, int_n goes high.
- R10: int_vec is 0xC7 while flag A is up, otherwise 0xCF while flag B is up, otherwise 0x00. While no register is read, rd_data equals int_vec.
- R11: While rst is high, every register returns to its reset value and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Bus address |
| wr_data | input | 8 | Bus write data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| io_req_n | input | 1 | I/O request strobe, active low |
| mem_req_n | input | 1 | Memory request strobe, active low |
| rd_data | output | 8 | Read data or interrupt vector |
| doe | output | 1 | Read data output enable |
| int_n | output | 1 | Interrupt request, active low |
| int_vec | output | 8 | Vector of the highest-priority pending interrupt |
| stat_in | input | 8 | Value read at the status offset |
| cfg_out | output | 8 | Config register value |
| soft_out | output | 8 | Soft-set register value |
| soft_clr | input | 8 | Per-bit hardware clear of the soft-set register |
| wstb_out | output | 8 | Write-strobe register value |
| wstb_pulse | output | 1 | One-cycle pulse after a write-strobe write |
| rstb_in | input | 8 | Value read at the read-strobe offset |
| rstb_pulse | output | 1 | One-cycle pulse after a read-strobe read |
| irq_set | input | 2x8 | Per-bit set inputs, index 0 for A, 1 for B |

## Verification
Read data and doe are combinational, so the bench samples them while the strobes are still held, before the edge that ends the access. Register contents and both pulses change at the edge of the access. The bench reads them at the falling edge right after it, and checks at the next falling edge that each pulse has dropped. int_n and int_vec sit one more register behind the interrupt status. The bench therefore lets one extra edge pass after any set, clear or mask change, and samples int_n once before that edge to confirm the lag.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

  typedef enum logic [2:0] {
    RK_STATUS,
    RK_CONFIG,
    RK_SOFTSET,
    RK_WSTROBE,
    RK_RSTROBE,
    RK_IRQ,
    RK_MASK
  } reg_kind_e;

  localparam int NUM_IRQ  = 2;
  localparam int NUM_REGS = 5 + 2 * NUM_IRQ;
  localparam int OFF_W    = $clog2(NUM_REGS);

  localparam int OFF_STATUS   = 0;
  localparam int OFF_CONFIG   = 1;
  localparam int OFF_SOFT     = 2;
  localparam int OFF_WSTB     = 3;
  localparam int OFF_RSTB     = 4;
  localparam int OFF_IRQ_BASE = 5;

  function automatic reg_kind_e kind_at(input int off);
    if (off == OFF_STATUS) return RK_STATUS;
    if (off == OFF_CONFIG) return RK_CONFIG;
    if (off == OFF_SOFT)   return RK_SOFTSET;
    if (off == OFF_WSTB)   return RK_WSTROBE;
    if (off == OFF_RSTB)   return RK_RSTROBE;
    if (((off - OFF_IRQ_BASE) % 2) == 0) return RK_IRQ;
    return RK_MASK;
  endfunction

  function automatic logic writable(input reg_kind_e k);
    return !(k == RK_STATUS || k == RK_RSTROBE);
  endfunction

endpackage

// File: rtl/rb_decode.sv
module rb_decode
  import rbank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter bit MEM_MAPPED = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic                io_req_n,
  input  logic                mem_req_n,
  output logic                bank_sel,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic [NUM_REGS-1:0] wr_sel
);
  localparam int HI_W = ADDR_W - OFF_W;
  localparam logic [HI_W-1:0] BANK_ID = BASE_ADDR[ADDR_W-1:OFF_W];

  logic             req_n;
  logic [OFF_W-1:0] off;

  assign req_n    = MEM_MAPPED ? mem_req_n : io_req_n;
  assign bank_sel = (addr[ADDR_W-1:OFF_W] == BANK_ID) && !req_n;
  assign off      = addr[OFF_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign rd_sel[i] = bank_sel && (off == OFF_W'(i)) && !rd_n;
    if (writable(kind_at(i))) begin : g_wr
      assign wr_sel[i] = bank_sel && (off == OFF_W'(i)) && !wr_n;
    end else begin : g_ro
      assign wr_sel[i] = 1'b0;
    end
  end

  // R3: at most one register answers a read
  assert_rd_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_sel));
  // R1: writes land only on one register
  assert_wr_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

endmodule

// File: rtl/rb_cfg_reg.sv
module rb_cfg_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= RST_VAL;
    else if (wr_sel) q <= wr_data;
  end

  // R4: value holds when no write is selected
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(q));

endmodule

// File: rtl/rb_softset_reg.sv
module rb_softset_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] set_bits;

  assign set_bits = wr_sel ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= (q | set_bits) & ~clr;
  end

  // R5: cleared bits are low after the edge, whatever was written
  assert_clr_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (clr != '0) |=> ((q & $past(clr)) == '0));

endmodule

// File: rtl/rb_irq_reg.sv
module rb_irq_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q,
  output logic         flag
);
  logic [W-1:0] clr_bits;

  assign clr_bits = wr_sel ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      flag <= 1'b0;
    end else begin
      q    <= (set | q) & ~clr_bits;
      flag <= |(q & ~mask);
    end
  end

  // R8: a bit written as 1 is clear after the edge
  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> ((q & $past(wr_data)) == '0));
  // R8: bits that are set stay set unless cleared
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> ((q & $past(q)) == $past(q)));
  // R9: an unmasked pending bit raises the flag one edge later
  assert_flag_R9: assert property (@(posedge clk) disable iff (rst)
    ((q & ~mask) != '0) |=> flag);

endmodule

// File: rtl/rb_read_mux.sv
module rb_read_mux
  import rbank_pkg::*;
#(
  parameter int W = 8,
  parameter logic [NUM_IRQ-1:0][W-1:0] VECS = '0
) (
  input  logic [NUM_REGS-1:0]        rd_sel,
  input  logic [NUM_REGS-1:0][W-1:0] vals,
  input  logic [NUM_IRQ-1:0]         flags,
  output logic [W-1:0]               rd_data,
  output logic                       doe,
  output logic [W-1:0]               int_vec
);
  always_comb begin
    int_vec = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (flags[i]) int_vec = VECS[i];
    end
  end

  always_comb begin
    rd_data = int_vec;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (rd_sel[i]) rd_data = vals[i];
    end
  end

  assign doe = |rd_sel;

endmodule

// File: rtl/periph_regbank.sv
module periph_regbank
  import rbank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter bit MEM_MAPPED = 1'b0,
  parameter logic [DATA_W-1:0] CFG_RST  = 8'hA5,
  parameter logic [DATA_W-1:0] SOFT_RST = 8'h0F,
  parameter logic [DATA_W-1:0] WSTB_RST = 8'h00,
  parameter logic [DATA_W-1:0] MASK_RST = 8'hFF,
  parameter logic [NUM_IRQ-1:0][DATA_W-1:0] IRQ_VECS = {8'hCF, 8'hC7}
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            rd_n,
  input  logic                            wr_n,
  input  logic                            io_req_n,
  input  logic                            mem_req_n,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            doe,
  output logic                            int_n,
  output logic [DATA_W-1:0]               int_vec,
  input  logic [DATA_W-1:0]               stat_in,
  output logic [DATA_W-1:0]               cfg_out,
  output logic [DATA_W-1:0]               soft_out,
  input  logic [DATA_W-1:0]               soft_clr,
  output logic [DATA_W-1:0]               wstb_out,
  output logic                            wstb_pulse,
  input  logic [DATA_W-1:0]               rstb_in,
  output logic                            rstb_pulse,
  input  logic [NUM_IRQ-1:0][DATA_W-1:0]  irq_set
);
  logic                              bank_sel;
  logic [NUM_REGS-1:0]               rd_sel;
  logic [NUM_REGS-1:0]               wr_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0]   rd_vals;
  logic [NUM_IRQ-1:0][DATA_W-1:0]    irq_q;
  logic [NUM_IRQ-1:0][DATA_W-1:0]    mask_q;
  logic [NUM_IRQ-1:0]                irq_flag;

  rb_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MEM_MAPPED(MEM_MAPPED)) u_dec (
    .clk, .rst, .addr, .rd_n, .wr_n, .io_req_n, .mem_req_n,
    .bank_sel, .rd_sel, .wr_sel
  );

  rb_cfg_reg #(.W(DATA_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk, .rst, .wr_sel(wr_sel[OFF_CONFIG]), .wr_data, .q(cfg_out)
  );

  rb_softset_reg #(.W(DATA_W), .RST_VAL(SOFT_RST)) u_soft (
    .clk, .rst, .wr_sel(wr_sel[OFF_SOFT]), .wr_data, .clr(soft_clr), .q(soft_out)
  );

  rb_cfg_reg #(.W(DATA_W), .RST_VAL(WSTB_RST)) u_wstb (
    .clk, .rst, .wr_sel(wr_sel[OFF_WSTB]), .wr_data, .q(wstb_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wstb_pulse <= 1'b0;
      rstb_pulse <= 1'b0;
    end else begin
      wstb_pulse <= wr_sel[OFF_WSTB];
      rstb_pulse <= rd_sel[OFF_RSTB];
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    localparam int OFF_I = OFF_IRQ_BASE + 2 * g;
    localparam int OFF_M = OFF_I + 1;

    rb_cfg_reg #(.W(DATA_W), .RST_VAL(MASK_RST)) u_mask (
      .clk, .rst, .wr_sel(wr_sel[OFF_M]), .wr_data, .q(mask_q[g])
    );

    rb_irq_reg #(.W(DATA_W)) u_irq (
      .clk, .rst, .set(irq_set[g]), .wr_sel(wr_sel[OFF_I]), .wr_data,
      .mask(mask_q[g]), .q(irq_q[g]), .flag(irq_flag[g])
    );

    assign rd_vals[OFF_I] = irq_q[g];
    assign rd_vals[OFF_M] = mask_q[g];
  end

  assign rd_vals[OFF_STATUS] = stat_in;
  assign rd_vals[OFF_CONFIG] = cfg_out;
  assign rd_vals[OFF_SOFT]   = soft_out;
  assign rd_vals[OFF_WSTB]   = wstb_out;
  assign rd_vals[OFF_RSTB]   = rstb_in;

  rb_read_mux #(.W(DATA_W), .VECS(IRQ_VECS)) u_mux (
    .rd_sel, .vals(rd_vals), .flags(irq_flag),
    .rd_data, .doe, .int_vec
  );

  assign int_n = ~|irq_flag;

  // R1: nothing is driven outside the selected window
  assert_no_doe_outside_R1: assert property (@(posedge clk) disable iff (rst)
    !bank_sel |-> !doe);
  // R1: a write select only appears under a low write strobe
  assert_wr_needs_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    (|wr_sel) |-> !wr_n);
  // R6: the write pulse coincides with the freshly loaded value
  assert_wstb_value_R6: assert property (@(posedge clk) disable iff (rst)
    wstb_pulse |-> (wstb_out == $past(wr_data)));
  // R6: the pulse lasts one cycle for a one-cycle write
  assert_wstb_single_R6: assert property (@(posedge clk) disable iff (rst)
    (wstb_pulse && !wr_sel[OFF_WSTB]) |=> !wstb_pulse);
  // R10: the vector is on the data lines when nothing is read
  assert_vec_fallback_R10: assert property (@(posedge clk) disable iff (rst)
    !doe |-> (rd_data == int_vec));

endmodule

// File: tb/tb_periph_regbank.sv
module tb_periph_regbank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wr_data = '0;
  logic rd_n = 1'b1, wr_n = 1'b1, io_req_n = 1'b1, mem_req_n = 1'b1;
  logic [7:0]  rd_data, int_vec, cfg_out, soft_out, wstb_out;
  logic        doe, int_n, wstb_pulse, rstb_pulse;
  logic [7:0]  stat_in = '0, soft_clr = '0, rstb_in = '0;
  logic [1:0][7:0] irq_set = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  periph_regbank dut (
    .clk, .rst, .addr, .wr_data, .rd_n, .wr_n, .io_req_n, .mem_req_n,
    .rd_data, .doe, .int_n, .int_vec, .stat_in, .cfg_out, .soft_out, .soft_clr,
    .wstb_out, .wstb_pulse, .rstb_in, .rstb_pulse, .irq_set
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input bit use_mem = 1'b0);
    @(negedge clk);
    addr = a; wr_data = d; wr_n = 1'b0;
    if (use_mem) mem_req_n = 1'b0; else io_req_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; io_req_n = 1'b1; mem_req_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; rd_n = 1'b0; io_req_n = 1'b0;
    #2;
    d = rd_data; oe = doe;
    @(negedge clk);
    rd_n = 1'b1; io_req_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic oe;
    chk("R11 cfg reset", cfg_out, 8'hA5);
    chk("R11 soft reset", soft_out, 8'h0F);
    chk("R11 wstb reset", wstb_out, 8'h00);
    chk("R11 int_n idle", int_n, 1'b1);
    chk("R11 pulses low", {wstb_pulse, rstb_pulse}, 2'b00);
    bus_rd(16'h0046, d, oe);
    chk("R9 mask A reset 0xFF", d, 8'hFF);
    bus_rd(16'h0045, d, oe);
    chk("R8 irq A reset 0", d, 8'h00);
  endtask

  task automatic t_config();
    logic [7:0] d; logic oe;
    bus_wr(16'h0041, 8'h3C);
    chk("R4 cfg load", cfg_out, 8'h3C);
    bus_rd(16'h0041, d, oe);
    chk("R3 cfg readback", d, 8'h3C);
    chk("R3 doe on read", oe, 1'b1);
    stat_in = 8'h6B;
    bus_rd(16'h0040, d, oe);
    chk("R3 status read", d, 8'h6B);
  endtask

  task automatic t_softset();
    bus_wr(16'h0042, 8'h30);
    chk("R5 write ORs in", soft_out, 8'h3F);
    @(negedge clk); soft_clr = 8'h05;
    @(negedge clk); soft_clr = 8'h00;
    chk("R5 hardware clear", soft_out, 8'h3A);
    soft_clr = 8'h10;
    bus_wr(16'h0042, 8'h50);
    soft_clr = 8'h00;
    chk("R5 clear beats write", soft_out, 8'h6A);
  endtask

  task automatic t_wstrobe();
    bus_wr(16'h0043, 8'h5C);
    chk("R6 wstb value", wstb_out, 8'h5C);
    chk("R6 wstb pulse high", wstb_pulse, 1'b1);
    @(negedge clk);
    chk("R6 wstb pulse one cycle", wstb_pulse, 1'b0);
  endtask

  task automatic t_rstrobe();
    logic [7:0] d; logic oe;
    rstb_in = 8'h9D;
    chk("R7 no pulse before read", rstb_pulse, 1'b0);
    bus_rd(16'h0044, d, oe);
    chk("R7 rstb data", d, 8'h9D);
    chk("R7 rstb pulse high", rstb_pulse, 1'b1);
    @(negedge clk);
    chk("R7 rstb pulse one cycle", rstb_pulse, 1'b0);
  endtask

  task automatic t_outside();
    logic [7:0] d; logic oe;
    bus_wr(16'h0143, 8'hEE);
    chk("R1 outside write no strobe", wstb_pulse, 1'b0);
    chk("R1 outside write no change", wstb_out, 8'h5C);
    bus_rd(16'h0144, d, oe);
    chk("R1 outside read no doe", oe, 1'b0);
    chk("R1 outside read no pulse", rstb_pulse, 1'b0);
    bus_rd(16'h004B, d, oe);
    chk("R3 empty offset no doe", oe, 1'b0);
    chk("R10 empty offset gives vector", d, 8'h00);
  endtask

  task automatic t_reqsel();
    bus_wr(16'h0041, 8'h11, 1'b1);
    chk("R2 memory request ignored", cfg_out, 8'h3C);
  endtask

  task automatic t_irq();
    logic [7:0] d; logic oe;
    @(negedge clk); irq_set[0] = 8'h81;
    @(negedge clk); irq_set[0] = 8'h00;
    @(negedge clk);
    chk("R9 masked bits keep int_n high", int_n, 1'b1);
    bus_rd(16'h0045, d, oe);
    chk("R8 sticky bits held", d, 8'h81);
    bus_wr(16'h0046, 8'h7F);
    chk("R9 flag lags mask by one edge", int_n, 1'b1);
    @(negedge clk);
    chk("R9 int_n low after unmask", int_n, 1'b0);
    chk("R10 vector A", int_vec, 8'hC7);
    irq_set[0] = 8'h02;
    bus_wr(16'h0045, 8'h82);
    irq_set[0] = 8'h00;
    bus_rd(16'h0045, d, oe);
    chk("R8 clear beats set", d, 8'h01);
    chk("R9 int_n released", int_n, 1'b1);
  endtask

  task automatic t_vector();
    logic [7:0] d; logic oe;
    @(negedge clk); irq_set[0] = 8'h80; irq_set[1] = 8'h01;
    @(negedge clk); irq_set = '0;
    bus_wr(16'h0048, 8'hFE);
    @(negedge clk);
    chk("R10 A wins over B", int_vec, 8'hC7);
    bus_rd(16'h004F, d, oe);
    chk("R10 fallback read shows vector", d, 8'hC7);
    chk("R10 fallback read no doe", oe, 1'b0);
    bus_wr(16'h0045, 8'hFF);
    @(negedge clk);
    chk("R10 vector B after A cleared", int_vec, 8'hCF);
    chk("R9 int_n still low for B", int_n, 1'b0);
    bus_wr(16'h0047, 8'hFF);
    @(negedge clk);
    chk("R9 int_n high when none pending", int_n, 1'b1);
    chk("R10 vector idle", int_vec, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config();
    t_softset();
    t_wstrobe();
    t_rstrobe();
    t_outside();
    t_reqsel();
    t_irq();
    t_vector();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule